// File: doc/BRIEF.md
# Bus Breakpoint Comparator

This block watches two buses for debug breakpoints. One is the processor's own bus. The other is an internal system bus that several masters share. It has four break channels, and each channel has its own programmed state: a compare address, an address mask, and a condition word.

A channel fires on an observed cycle when three things hold. The unmasked address bits are equal. The cycle's bus, access kind and direction are all permitted by the condition word. For the system bus, the issuing master is also the one the channel names. A hit sets a sticky flag for that channel and that bus. It raises one break request toward the processor and starts a trigger pulse whose width software chooses.

Both bus inputs are monitor streams that carry only a valid strobe. The comparator never applies back-pressure, and it has no ready signal. The owning bus completes every cycle regardless, and each cycle that shows valid is judged exactly once, in the clock it appears. Software reaches the configuration, control and flag registers through a plain write strobe with a shared address. Read data is combinational from that address.

Top module: `bus_break_unit`

## Requirements
- R1: A channel compares an observed address with its compare address only on bits where its mask register holds 0. A mask bit of 1 excludes that address bit from the comparison.
- R2: The condition word has three two-bit groups. Bus select is bits [1:0]: 01 means processor bus, 10 means system bus, 11 means either. Access kind is bits [3:2]: 01 means instruction fetch, 10 means data access, 11 means either. Direction is bits [5:4]: 01 means read, 10 means write, 11 means either.
- R3: If any of the three groups in a channel's condition word is 00, that channel never hits. The condition word resets to 0.
- R4: The flag register holds processor-bus flags for channels 0..3 in bits [3:0] and system-bus flags in bits [7:4]. A flag stays set until software writes 0 to its bit. Writing 1 to a bit leaves that bit unchanged.
- R5: A hit in clock n sets the flag for the bus it occurred on, visible after edge n. When several channels hit in the same clock, every one of their flags is set, and a single one-cycle break request is raised in the clock after.
- R6: Bits [7:6] of the condition word name a system bus master. A system bus cycle counts only if its master identifier equals this field.
- R7: The control register's bits [1:0] select a trigger pulse of 1, 2, 4 or 8 clocks for the values 00, 01, 10 and 11. The pulse starts in the clock after a hit. A hit during a pulse restarts the full width.
- R8: When control bit 2 (trigger only) is 1, hits still set flags and pulse the trigger, but no break request is raised.
- R9: The break request carries the fixed level 15. It is raised only when the processor's interrupt mask level is 14 or lower. Flags are set whatever the mask level.
- R10: Registers are addressed as follows. Address bit 4 = 0 selects channel bits [3:2], with field bits [1:0]: 0 = compare address, 1 = mask, 2 = condition. Address 0x10 is control and 0x11 is flags. Every register reads back what was written, and all of them reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_valid | input | 1 | Processor bus cycle present |
| cpu_addr | input | 32 | Processor bus cycle address |
| cpu_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cpu_write | input | 1 | 1 = write, 0 = read |
| sys_valid | input | 1 | System bus cycle present |
| sys_addr | input | 32 | System bus cycle address |
| sys_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| sys_write | input | 1 | 1 = write, 0 = read |
| sys_master | input | 2 | Identifier of the system bus master |
| int_mask | input | 4 | Processor interrupt mask level |
| brk_req | output | 1 | One-cycle break request |
| trig_out | output | 1 | Trigger pulse |

## Verification
Two situations are hard to reach from the ports. One is several channels hitting in one clock. The other is a hit that lands while a trigger pulse is still running. For the first, the stimulus programs three channels with the same address and qualifiers, leaves the fourth disabled, and presents one processor cycle. It then checks that exactly those three flags are set and that the request is high for a single clock. For the second, the stimulus starts a four-clock pulse, lets two clocks run, and hits again. The trigger must then stay high for four further samples rather than ending after one. The vector table separately walks each condition group through its accepting and rejecting codes on both buses.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int MID_W = 2;
  localparam int SEL_W = 2;
  localparam logic [3:0] BRK_LEVEL = 4'd15;

  typedef struct packed {
    logic [MID_W-1:0] mid;
    logic [1:0]       dir;
    logic [1:0]       acc;
    logic [1:0]       bus;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  // option 0 -> bit 0 of group, option 1 -> bit 1 of group
  function automatic logic grp_allows(input logic [1:0] grp, input logic second);
    return second ? grp[1] : grp[0];
  endfunction
endpackage

// File: rtl/bbu_regfile.sv
module bbu_regfile
  import bbu_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32,
  parameter int RA_W   = $clog2(NCH) + 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [RA_W-1:0]              addr,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [ADDR_W-1:0]            rdata,
  input  logic [NCH-1:0]               cpu_hit,
  input  logic [NCH-1:0]               sys_hit,
  output logic [NCH-1:0][ADDR_W-1:0]   ch_addr,
  output logic [NCH-1:0][ADDR_W-1:0]   ch_mask,
  output cond_t [NCH-1:0]              ch_cond,
  output logic [SEL_W-1:0]             width_sel,
  output logic                         trig_only
);
  localparam int CH_W = $clog2(NCH);
  localparam int FL_W = 2 * NCH;

  logic [FL_W-1:0] flags;
  logic [FL_W-1:0] hits;
  logic [FL_W-1:0] keep;
  logic            is_glob;
  logic            clr_en;
  logic [CH_W-1:0] ch_idx;

  assign is_glob = addr[RA_W-1];
  assign ch_idx  = addr[CH_W+1:2];
  assign clr_en  = wr_en && is_glob && addr[0];
  assign hits    = {sys_hit, cpu_hit};
  assign keep    = clr_en ? wdata[FL_W-1:0] : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_addr   <= '0;
      ch_mask   <= '0;
      ch_cond   <= '0;
      width_sel <= '0;
      trig_only <= 1'b0;
      flags     <= '0;
    end else begin
      if (wr_en && !is_glob) begin
        case (addr[1:0])
          2'd0:    ch_addr[ch_idx] <= wdata;
          2'd1:    ch_mask[ch_idx] <= wdata;
          2'd2:    ch_cond[ch_idx] <= cond_t'(wdata[COND_W-1:0]);
          default: ;
        endcase
      end
      if (wr_en && is_glob && !addr[0])
        {trig_only, width_sel} <= wdata[SEL_W:0];
      // a hit in the same clock as a clearing write wins
      flags <= (flags & keep) | hits;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_glob) begin
      if (addr[0]) rdata[FL_W-1:0]  = flags;
      else         rdata[SEL_W:0]   = {trig_only, width_sel};
    end else begin
      case (addr[1:0])
        2'd0:    rdata = ch_addr[ch_idx];
        2'd1:    rdata = ch_mask[ch_idx];
        2'd2:    rdata[COND_W-1:0] = ch_cond[ch_idx];
        default: rdata = '0;
      endcase
    end
  end

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_en) |-> (($past(flags) & ~flags) == '0));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(hits)) |-> ((flags & $past(hits)) == $past(hits)));
endmodule

// File: rtl/bbu_chan_cmp.sv
module bbu_chan_cmp
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  cond_t             cond,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  input  logic              cpu_write,
  input  logic              sys_valid,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic              sys_fetch,
  input  logic              sys_write,
  input  logic [MID_W-1:0]  sys_master,
  output logic              cpu_hit,
  output logic              sys_hit
);
  logic armed;
  logic cpu_addr_eq, sys_addr_eq;
  logic cpu_kind_ok, sys_kind_ok;

  assign armed       = (cond.bus != 2'b00) && (cond.acc != 2'b00) && (cond.dir != 2'b00);
  assign cpu_addr_eq = ((cpu_addr ^ cfg_addr) & ~cfg_mask) == '0;
  assign sys_addr_eq = ((sys_addr ^ cfg_addr) & ~cfg_mask) == '0;
  assign cpu_kind_ok = grp_allows(cond.acc, !cpu_fetch) && grp_allows(cond.dir, cpu_write);
  assign sys_kind_ok = grp_allows(cond.acc, !sys_fetch) && grp_allows(cond.dir, sys_write);

  assign cpu_hit = armed && cpu_valid && cond.bus[0] && cpu_addr_eq && cpu_kind_ok;
  assign sys_hit = armed && sys_valid && cond.bus[1] && sys_addr_eq && sys_kind_ok
                   && (sys_master == cond.mid);

  assert_disabled_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond.bus == 2'b00) || (cond.acc == 2'b00) || (cond.dir == 2'b00)) |-> !(cpu_hit || sys_hit));

  assert_master_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_hit |-> (sys_valid && sys_master == cond.mid));
endmodule

// File: rtl/bbu_pulse.sv
module bbu_pulse
  import bbu_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [SW-1:0] sel,
  output logic          trig
);
  localparam int MAXW  = 1 << ((1 << SW) - 1);
  localparam int CNT_W = $clog2(MAXW + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] width;

  assign width = CNT_W'(1) << sel;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (fire)        cnt <= width;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign trig = (cnt != '0);

  assert_trig_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trig);

  assert_trig_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAXW));
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [$clog2(NCH)+2:0]    reg_addr,
  input  logic [ADDR_W-1:0]         reg_wdata,
  output logic [ADDR_W-1:0]         reg_rdata,
  input  logic                      cpu_valid,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      cpu_fetch,
  input  logic                      cpu_write,
  input  logic                      sys_valid,
  input  logic [ADDR_W-1:0]         sys_addr,
  input  logic                      sys_fetch,
  input  logic                      sys_write,
  input  logic [MID_W-1:0]          sys_master,
  input  logic [3:0]                int_mask,
  output logic                      brk_req,
  output logic                      trig_out
);
  localparam int RA_W = $clog2(NCH) + 3;

  logic [NCH-1:0][ADDR_W-1:0] ch_addr;
  logic [NCH-1:0][ADDR_W-1:0] ch_mask;
  cond_t [NCH-1:0]            ch_cond;
  logic [SEL_W-1:0]           width_sel;
  logic                       trig_only;
  logic [NCH-1:0]             cpu_hit, sys_hit;
  logic                       any_hit;

  bbu_regfile #(.NCH(NCH), .ADDR_W(ADDR_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cpu_hit(cpu_hit), .sys_hit(sys_hit),
    .ch_addr(ch_addr), .ch_mask(ch_mask), .ch_cond(ch_cond),
    .width_sel(width_sel), .trig_only(trig_only)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bbu_chan_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .cfg_addr(ch_addr[c]), .cfg_mask(ch_mask[c]), .cond(ch_cond[c]),
      .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch), .cpu_write(cpu_write),
      .sys_valid(sys_valid), .sys_addr(sys_addr), .sys_fetch(sys_fetch), .sys_write(sys_write),
      .sys_master(sys_master), .cpu_hit(cpu_hit[c]), .sys_hit(sys_hit[c])
    );
  end

  assign any_hit = (|cpu_hit) || (|sys_hit);

  bbu_pulse #(.SW(SEL_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(any_hit), .sel(width_sel), .trig(trig_out)
  );

  // level 15 is taken only below a mask of 15
  always_ff @(posedge clk) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= any_hit && !trig_only && (int_mask < BRK_LEVEL);
  end

  assert_trig_only_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig_only) |-> !brk_req);

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_mask) == BRK_LEVEL) |-> !brk_req);

  assert_req_has_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(any_hit));
endmodule

// File: tb/test_bus_break_unit.sv
module test_bus_break_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_valid = 1'b0, cpu_fetch = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        sys_valid = 1'b0, sys_fetch = 1'b0, sys_write = 1'b0;
  logic [31:0] sys_addr = '0;
  logic [1:0]  sys_master = '0;
  logic [3:0]  int_mask = '0;
  logic        brk_req, trig_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bus_break_unit i_bus_break_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch), .cpu_write(cpu_write),
    .sys_valid(sys_valid), .sys_addr(sys_addr), .sys_fetch(sys_fetch), .sys_write(sys_write),
    .sys_master(sys_master), .int_mask(int_mask), .brk_req(brk_req), .trig_out(trig_out)
  );

  localparam logic [4:0] A_CTL = 5'h10;
  localparam logic [4:0] A_FLG = 5'h11;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] m;
    logic [7:0]  cond;
    logic        onsys;
    logic [31:0] ba;
    logic        f;
    logic        w;
    logic [1:0]  mid;
    logic        ecpu;
    logic        esys;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h1000, 32'h0,    8'h3D, 1'b0, 32'h1000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{32'h1000, 32'h0,    8'h3D, 1'b0, 32'h1004, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{32'h1000, 32'hFF,   8'h3D, 1'b0, 32'h10AB, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{32'h2000, 32'h0,    8'h1D, 1'b0, 32'h2000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{32'h2000, 32'h0,    8'h35, 1'b0, 32'h2000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{32'h3000, 32'h0,    8'hBE, 1'b1, 32'h3000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1},
    '{32'h3000, 32'h0,    8'hBE, 1'b1, 32'h3000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
    '{32'h3000, 32'h0,    8'h3D, 1'b1, 32'h3000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{32'h4000, 32'h0,    8'h0F, 1'b0, 32'h4000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{32'h5000, 32'hF,    8'h6B, 1'b1, 32'h5003, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // one observed cycle; returns at the negedge after the capturing edge
  task automatic bus_cycle(input logic onsys, input logic [31:0] a, input logic f,
                           input logic w, input logic [1:0] mid);
    @(negedge clk);
    if (onsys) begin
      sys_valid = 1'b1; sys_addr = a; sys_fetch = f; sys_write = w; sys_master = mid;
    end else begin
      cpu_valid = 1'b1; cpu_addr = a; cpu_fetch = f; cpu_write = w;
    end
    @(negedge clk);
    cpu_valid = 1'b0; sys_valid = 1'b0;
  endtask

  task automatic count_trig(output int n);
    n = 0;
    while (trig_out && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R10, R3 condition words reset to 0)
    rd(A_FLG, d);   chk("R10 reset flags", d, 32'h0);
    rd(A_CTL, d);   chk("R10 reset ctl", d, 32'h0);
    rd(5'h0A, d);   chk("R3 reset cond ch2", d, 32'h0);
    chk("R10 reset req", {31'b0, brk_req}, 32'h0);
    chk("R10 reset trig", {31'b0, trig_out}, 32'h0);

    // R10 readback
    wr(5'h09, 32'hDEAD_BEEF);
    rd(5'h09, d);   chk("R10 mask ch2 readback", d, 32'hDEAD_BEEF);
    wr(5'h09, 32'h0);

    // table walk on channel 0: R1 R2 R3 R6 R5
    for (int i = 0; i < NV; i++) begin
      wr(5'h00, TBL[i].a);
      wr(5'h01, TBL[i].m);
      wr(5'h02, {24'b0, TBL[i].cond});
      wr(A_FLG, 32'h0);
      bus_cycle(TBL[i].onsys, TBL[i].ba, TBL[i].f, TBL[i].w, TBL[i].mid);
      chk($sformatf("R2 R5 vec%0d req", i), {31'b0, brk_req},
          {31'b0, TBL[i].ecpu | TBL[i].esys});
      rd(A_FLG, d);
      chk($sformatf("R1 R6 vec%0d flags", i), d,
          {27'b0, TBL[i].esys, 3'b0, TBL[i].ecpu});
    end

    // R5: three channels hit at once, ch2 disabled
    wr(5'h02, 32'h0);
    wr(5'h00, 32'h8000); wr(5'h01, 32'h0); wr(5'h02, 32'h3D);
    wr(5'h04, 32'h8000); wr(5'h05, 32'h0); wr(5'h06, 32'h3D);
    wr(5'h0C, 32'h8000); wr(5'h0D, 32'h0); wr(5'h0E, 32'h3D);
    wr(A_FLG, 32'h0);
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    chk("R5 single req high", {31'b0, brk_req}, 32'h1);
    rd(A_FLG, d);   chk("R5 multi flags", d, 32'h0B);
    @(negedge clk);
    chk("R5 req one cycle", {31'b0, brk_req}, 32'h0);

    // R4 sticky and write-0 clear
    bus_cycle(1'b0, 32'h9000, 1'b0, 1'b0, 2'd0);
    rd(A_FLG, d);   chk("R4 flags persist", d, 32'h0B);
    wr(A_FLG, 32'hFE);
    rd(A_FLG, d);   chk("R4 clear bit0 only", d, 32'h0A);
    wr(A_FLG, 32'hFF);
    rd(A_FLG, d);   chk("R4 write 1 no set", d, 32'h0A);
    wr(A_FLG, 32'h0);

    // R7 widths
    for (int s = 0; s < 4; s++) begin
      wr(A_CTL, s);
      bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
      count_trig(n);
      chk($sformatf("R7 width sel%0d", s), n, 32'(1 << s));
    end

    // R7 restart mid pulse (width 4)
    wr(A_CTL, 32'h2);
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    count_trig(n);
    chk("R7 restart full width", n, 32'd4);

    // R8 trigger only
    wr(A_FLG, 32'h0);
    wr(A_CTL, 32'h4);
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    chk("R8 no req", {31'b0, brk_req}, 32'h0);
    chk("R8 trig still", {31'b0, trig_out}, 32'h1);
    rd(A_FLG, d);   chk("R8 flags set", d, 32'h0B);
    wr(A_CTL, 32'h0);

    // R9 mask level
    wr(A_FLG, 32'h0);
    int_mask = 4'd15;
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    chk("R9 mask 15 no req", {31'b0, brk_req}, 32'h0);
    rd(A_FLG, d);   chk("R9 flags at mask 15", d, 32'h0B);
    int_mask = 4'd14;
    bus_cycle(1'b0, 32'h8000, 1'b0, 1'b0, 2'd0);
    chk("R9 mask 14 req", {31'b0, brk_req}, 32'h1);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule